// File: doc/BRIEF.md
# Power-on and flush reset sequencer

This block orders the reset steps of a switch chip that has several clock and logic domains. A filtered, active-low hard reset pin restarts the whole sequence. The sequencer then waits for a clock-start event from the management interface. If the internal PLL is strapped in, that event takes the PLL out of reset, and the high-speed serial-link logic is pulsed into reset after a PLL settle delay. If the PLL is bypassed, the link reset follows the event at once. When the link reset pulse ends, a core-logic flush runs for a fixed time. After the flush the chip sits in standby, with its pads disabled and its input data dropped.

A flush can also be started on its own, either by a soft-reset command or when a built-in self test completes. Such a flush leaves the PLL and the link logic alone. One status bit stays high from the acceptance of a reset until the flush is over. A flag tells the management interface to throw away the first response it returns after any reset.

All waits are counted in clock cycles. They are derived from a clock-frequency parameter, with one tenth of a millisecond for the PLL settle and one millisecond for the flush.

Top module: `rstseq_ctrl`

## Requirements
- R1: A hard reset is taken only when `hard_rst_n` is sampled low on MIN_LOW (default 4) consecutive rising edges, and it takes effect on the last of those edges. A shorter low pulse has no effect on any output.
- R2: After a hard reset the block waits for `clk_start_i`. While it waits, `pll_rst_o`=1, `busy_o`=1, and `link_rst_o`, `flush_en_o` and `standby_o` are all 0. A `clk_start_i` pulse in any other state has no effect.
- R3: If `pll_en_i`=1 when a clock start is taken, `pll_rst_o` goes to 0 on that edge. `link_rst_o` rises PLL_CYC = CLK_HZ/10000 cycles later.
- R4: If `pll_en_i`=0 when a clock start is taken, `link_rst_o` rises on that edge and `pll_rst_o` stays at 1.
- R5: `link_rst_o` stays high for LINK_W cycles. `flush_en_o` then stays high for FLUSH_CYC = CLK_HZ/1000 cycles.
- R6: `busy_o` (status bit 15) is 1 from a taken reset or flush trigger until the flush completes, and 0 afterwards.
- R7: When the flush ends, `standby_o` rises on the same edge that `flush_en_o` falls.
- R8: A `soft_rst_i` pulse in standby starts a FLUSH_CYC-cycle flush on the next edge. `link_rst_o` stays 0 and `pll_rst_o` keeps its value.
- R9: A `bist_done_i` pulse in standby starts a flush in the same way as a soft reset.
- R10: A soft-reset or BIST trigger that arrives while a flush is running is ignored, and the flush ends on its original schedule.
- R11: A taken hard reset aborts any step in progress and puts the block in the wait-for-clock-start state.
- R12: `discard_rsp_o` is set by a taken hard reset or by a flush started from standby. It clears on the edge after the first `rsp_valid_i` seen while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| hard_rst_n | input | 1 | Active-low hard reset pin, filtered |
| pll_en_i | input | 1 | Strap: internal PLL in use |
| clk_start_i | input | 1 | Clock-start event strobe |
| soft_rst_i | input | 1 | Soft-reset command strobe |
| bist_done_i | input | 1 | Self-test completion strobe |
| rsp_valid_i | input | 1 | Management response issued |
| pll_rst_o | output | 1 | PLL reset, high = held |
| link_rst_o | output | 1 | Serial-link logic reset pulse |
| flush_en_o | output | 1 | Core flush-reset enable |
| busy_o | output | 1 | Status bit 15, sequence in progress |
| standby_o | output | 1 | Standby: pads disabled, inputs dropped |
| discard_rsp_o | output | 1 | Discard the next management response |

## Verification
The bench builds the block with CLK_HZ=100000, which gives a 10-cycle PLL settle and a 100-cycle flush. It also sets LINK_W=4 and keeps MIN_LOW=4. With these short windows every edge of the sequence can be checked cycle by cycle, both with and without the PLL. The bench also fires triggers in the middle of a flush and aborts sequences with a hard reset. At the production clock rate the flush alone would last tens of thousands of cycles.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   typedef enum logic [2:0] {
      SQ_WAIT_START = 3'd0,
      SQ_PLL_WAIT   = 3'd1,
      SQ_LINK_RST   = 3'd2,
      SQ_FLUSH      = 3'd3,
      SQ_STANDBY    = 3'd4
   } sq_state_t;
endpackage

// File: rtl/rstseq_pin_qual.sv
module rstseq_pin_qual #(
   parameter int MIN_LOW = 4
) (
   input  logic clk,
   input  logic pin_n,
   output logic take_o
);
   generate
      if (MIN_LOW < 1) begin : g_bad
         $error("MIN_LOW must be at least 1");
      end
      if (MIN_LOW == 1) begin : g_direct
         assign take_o = !pin_n;
      end else begin : g_count
         localparam int QW = $clog2(MIN_LOW + 1);
         logic [QW-1:0] low_cnt;
         always_ff @(posedge clk) begin
            if (pin_n)
               low_cnt <= '0;
            else if (low_cnt != QW'(MIN_LOW))
               low_cnt <= low_cnt + 1'b1;
         end
         assign take_o = !pin_n && (low_cnt >= QW'(MIN_LOW - 1));
      end
   endgenerate
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          zero_o
);
   logic [CW-1:0] cnt;
   always_ff @(posedge clk) begin
      if (load_i)
         cnt <= load_val_i;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end
   assign zero_o = (cnt == '0);
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
   import rstseq_pkg::*;
#(
   parameter int CLK_HZ  = 50_000_000,
   parameter int LINK_W  = 16,
   parameter int MIN_LOW = 4
) (
   input  logic clk,
   input  logic hard_rst_n,
   input  logic pll_en_i,
   input  logic clk_start_i,
   input  logic soft_rst_i,
   input  logic bist_done_i,
   input  logic rsp_valid_i,
   output logic pll_rst_o,
   output logic link_rst_o,
   output logic flush_en_o,
   output logic busy_o,
   output logic standby_o,
   output logic discard_rsp_o
);
   localparam int PLL_CYC   = CLK_HZ / 10_000;
   localparam int FLUSH_CYC = CLK_HZ / 1_000;
   localparam int CW        = $clog2(FLUSH_CYC + 1);

   generate
      if (PLL_CYC < 1) begin : g_bad_hz
         $error("CLK_HZ too small for the PLL settle window");
      end
      if (LINK_W < 1 || LINK_W > FLUSH_CYC) begin : g_bad_link
         $error("LINK_W out of range");
      end
   endgenerate

   logic      rst_take;
   logic      tmr_load;
   logic      tmr_zero;
   logic [CW-1:0] tmr_val;
   sq_state_t state, state_nx;
   logic      flush_trig;

   rstseq_pin_qual #(.MIN_LOW(MIN_LOW)) u_qual (
      .clk    (clk),
      .pin_n  (hard_rst_n),
      .take_o (rst_take)
   );

   rstseq_timer #(.CW(CW)) u_tmr (
      .clk        (clk),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   assign flush_trig = soft_rst_i || bist_done_i;

   always_comb begin
      state_nx = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (rst_take) begin
         state_nx = SQ_WAIT_START;
      end else begin
         unique case (state)
            SQ_WAIT_START: if (clk_start_i) begin
               tmr_load = 1'b1;
               if (pll_en_i) begin
                  state_nx = SQ_PLL_WAIT;
                  tmr_val  = CW'(PLL_CYC - 1);
               end else begin
                  state_nx = SQ_LINK_RST;
                  tmr_val  = CW'(LINK_W - 1);
               end
            end
            SQ_PLL_WAIT: if (tmr_zero) begin
               state_nx = SQ_LINK_RST;
               tmr_load = 1'b1;
               tmr_val  = CW'(LINK_W - 1);
            end
            SQ_LINK_RST: if (tmr_zero) begin
               state_nx = SQ_FLUSH;
               tmr_load = 1'b1;
               tmr_val  = CW'(FLUSH_CYC - 1);
            end
            SQ_FLUSH: if (tmr_zero) state_nx = SQ_STANDBY;
            SQ_STANDBY: if (flush_trig) begin
               state_nx = SQ_FLUSH;
               tmr_load = 1'b1;
               tmr_val  = CW'(FLUSH_CYC - 1);
            end
            default: state_nx = SQ_WAIT_START;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      state <= state_nx;
      if (rst_take)
         pll_rst_o <= 1'b1;
      else if (state == SQ_WAIT_START && clk_start_i && pll_en_i)
         pll_rst_o <= 1'b0;
      if (rst_take || (state == SQ_STANDBY && flush_trig))
         discard_rsp_o <= 1'b1;
      else if (rsp_valid_i)
         discard_rsp_o <= 1'b0;
   end

   assign link_rst_o = (state == SQ_LINK_RST);
   assign flush_en_o = (state == SQ_FLUSH);
   assign standby_o  = (state == SQ_STANDBY);
   assign busy_o     = (state != SQ_STANDBY);

   // R3
   pll_release_chk: assert property (@(posedge clk) disable iff (rst_take)
      $fell(pll_rst_o) |-> $past(clk_start_i && pll_en_i));
   // R4
   link_entry_chk: assert property (@(posedge clk) disable iff (rst_take)
      $rose(link_rst_o) |-> $past(!pll_rst_o || (clk_start_i && !pll_en_i)));
   // R5
   flush_entry_chk: assert property (@(posedge clk) disable iff (rst_take)
      $rose(flush_en_o) |-> $past(link_rst_o || (standby_o && flush_trig)));
   // R7
   standby_entry_chk: assert property (@(posedge clk) disable iff (rst_take)
      $rose(standby_o) |-> $past(flush_en_o));
   // R6
   busy_clear_chk: assert property (@(posedge clk) disable iff (rst_take)
      $fell(busy_o) |-> $past(flush_en_o));
   // R12
   discard_set_chk: assert property (@(posedge clk) disable iff (rst_take)
      ($rose(flush_en_o) && $past(standby_o)) |-> discard_rsp_o);
endmodule

// File: tb/rstseq_ctrl_bench.sv
module rstseq_ctrl_bench;
   logic clk = 1'b0;
   logic hard_rst_n = 1'b1;
   logic pll_en = 1'b1, clk_start = 1'b0, soft_rst = 1'b0, bist_done = 1'b0, rsp_valid = 1'b0;
   logic pll_rst, link_rst, flush_en, busy, standby, discard;
   int vecs = 0, errs = 0;
   bit done = 0;

   always #10 clk = ~clk;

   rstseq_ctrl #(.CLK_HZ(100_000), .LINK_W(4), .MIN_LOW(4)) u_rstseq_ctrl (
      .clk(clk), .hard_rst_n(hard_rst_n), .pll_en_i(pll_en), .clk_start_i(clk_start),
      .soft_rst_i(soft_rst), .bist_done_i(bist_done), .rsp_valid_i(rsp_valid),
      .pll_rst_o(pll_rst), .link_rst_o(link_rst), .flush_en_o(flush_en),
      .busy_o(busy), .standby_o(standby), .discard_rsp_o(discard)
   );

   task automatic chk(string req, logic act, logic exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hard_reset(int lows);
      hard_rst_n = 1'b0;
      wait_n(lows);
      hard_rst_n = 1'b1;
   endtask

   task automatic pulse(ref logic sig);
      sig = 1'b1;
      @(negedge clk);
      sig = 1'b0;
   endtask

   task automatic t_reset_state();
      hard_reset(6);
      wait_n(1);
      chk("R2 pll_rst", pll_rst, 1'b1);
      chk("R2 busy", busy, 1'b1);
      chk("R2 link", link_rst, 1'b0);
      chk("R2 flush", flush_en, 1'b0);
      chk("R2 standby", standby, 1'b0);
      chk("R12 discard after reset", discard, 1'b1);
      wait_n(5);
      chk("R2 still waiting", standby | flush_en | link_rst, 1'b0);
   endtask

   task automatic t_pll_seq();
      pll_en = 1'b1;
      pulse(clk_start);
      chk("R3 pll released", pll_rst, 1'b0);
      chk("R3 no link yet", link_rst, 1'b0);
      wait_n(9);
      chk("R3 link before settle", link_rst, 1'b0);
      wait_n(1);
      chk("R3 link after settle", link_rst, 1'b1);
      wait_n(3);
      chk("R5 link last cycle", link_rst, 1'b1);
      chk("R5 flush not yet", flush_en, 1'b0);
      wait_n(1);
      chk("R5 link ended", link_rst, 1'b0);
      chk("R5 flush started", flush_en, 1'b1);
      wait_n(99);
      chk("R5 flush last cycle", flush_en, 1'b1);
      chk("R6 busy in flush", busy, 1'b1);
      wait_n(1);
      chk("R7 standby", standby, 1'b1);
      chk("R7 flush ended", flush_en, 1'b0);
      chk("R6 busy cleared", busy, 1'b0);
   endtask

   task automatic t_nopll();
      hard_reset(4);
      chk("R11 exact four lows taken", standby, 1'b0);
      wait_n(1);
      pll_en = 1'b0;
      pulse(clk_start);
      chk("R4 link immediate", link_rst, 1'b1);
      chk("R4 pll stays reset", pll_rst, 1'b1);
      wait_n(3);
      chk("R4 link last", link_rst, 1'b1);
      wait_n(1);
      chk("R4 flush begins", flush_en, 1'b1);
      wait_n(100);
      chk("R4 standby", standby, 1'b1);
      chk("R4 pll still reset", pll_rst, 1'b1);
      pll_en = 1'b1;
   endtask

   task automatic t_soft();
      logic pll_before = pll_rst;
      pulse(soft_rst);
      chk("R8 flush started", flush_en, 1'b1);
      chk("R8 no link reset", link_rst, 1'b0);
      chk("R8 pll unchanged", pll_rst, pll_before);
      chk("R12 discard set by flush", discard, 1'b1);
      chk("R6 busy in soft flush", busy, 1'b1);
      wait_n(48);
      pulse(soft_rst);
      pulse(bist_done);
      wait_n(49);
      chk("R10 flush runs on", flush_en, 1'b1);
      chk("R8 no link during flush", link_rst, 1'b0);
      wait_n(1);
      chk("R10 flush ends on schedule", standby, 1'b1);
      chk("R8 pll still unchanged", pll_rst, pll_before);
   endtask

   task automatic t_bist();
      pulse(bist_done);
      chk("R9 flush from bist", flush_en, 1'b1);
      chk("R9 no link", link_rst, 1'b0);
      wait_n(99);
      chk("R9 flush last", flush_en, 1'b1);
      wait_n(1);
      chk("R9 standby", standby, 1'b1);
   endtask

   task automatic t_short_and_ignored();
      hard_reset(3);
      wait_n(1);
      chk("R1 short pulse ignored standby", standby, 1'b1);
      chk("R1 short pulse ignored busy", busy, 1'b0);
      pulse(clk_start);
      wait_n(1);
      chk("R2 clock start ignored", standby, 1'b1);
      chk("R2 no link on stray start", link_rst, 1'b0);
   endtask

   task automatic t_discard();
      pulse(rsp_valid);
      chk("R12 discard cleared", discard, 1'b0);
      pulse(rsp_valid);
      chk("R12 discard stays clear", discard, 1'b0);
   endtask

   task automatic t_abort();
      pulse(soft_rst);
      wait_n(20);
      hard_reset(4);
      chk("R11 flush aborted", flush_en, 1'b0);
      chk("R11 not standby", standby, 1'b0);
      chk("R11 pll reset", pll_rst, 1'b1);
      chk("R11 busy", busy, 1'b1);
      chk("R12 discard on hard reset", discard, 1'b1);
      wait_n(1);
      pulse(clk_start);
      wait_n(4);
      hard_reset(4);
      chk("R11 pll wait aborted", pll_rst, 1'b1);
      chk("R11 no link after abort", link_rst, 1'b0);
   endtask

   initial begin
      wait_n(2);
      t_reset_state();
      t_pll_seq();
      t_discard();
      t_short_and_ignored();
      t_soft();
      t_bist();
      t_nopll();
      t_abort();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end
endmodule